// File: doc/BRIEF.md
# Multi-Granule Tag Check Unit

This unit decides whether a memory access may proceed by comparing the 4-bit tag carried in the pointer with the tags kept in tag memory for every 16-byte granule that the access covers. Tag memory packs two granule tags into each byte. The even granule sits in the low nibble and the odd granule sits in the high nibble. The unit fetches these bytes one at a time through a simple request/response read port. It walks through the granules in ascending order and stops at the first tag that differs.

A job starts with a one-cycle `start_i` pulse. The pulse carries the pointer, the total access size and the element size, given as a base-2 logarithm. Two cases skip the check and pass at once. The first is top-byte tagging switched off for the pointer's half of the address space. The second is the match-all rule for that half being enabled while the pointer carries that half's reserved tag. If neither applies, the unit runs the walk. A failing access reports an address: the pointer advanced to the first element boundary at or after the start of the failing granule.

The state machine has five states. IDLE waits for start and either takes the bypass edge to DONE or takes the launch edge to FETCH. FETCH raises the read request for one cycle and moves to WAIT. WAIT holds until the response arrives and then moves to CMP. CMP compares one nibble and takes one of four edges:
- the mismatch edge to DONE;
- the final-granule edge to DONE;
- the same-byte edge back to CMP, which selects the high nibble;
- the next-byte edge to FETCH.

DONE raises `done_o` for one cycle and returns to IDLE.

Top module: `tag_check_unit`

## Requirements
- R1: After reset, `done_o`, `tag_req_o` and `pass_o` are 0, and `fault_addr_o` is 0.
- R2: Pointer bit 55 selects a half, and `tbi_en_i[bit55]` is that half's tagging enable. When that enable is 0, the job passes with no tag request, and `done_o` rises in the cycle after start is sampled.
- R3: When tagging is enabled for the selected half and `mall_en_i[bit55]` is 1, a pointer tag of 4'h0 (half 0) or 4'hF (half 1) makes the job pass with no tag request and one cycle of latency. Any other tag is checked.
- R4: The granule at virtual address `a` (bits [55:0]) has its tag in byte `a[55:5]` of tag memory. The tag is in bits [3:0] when `a[4]` is 0 and in bits [7:4] when `a[4]` is 1. The walk starts on the nibble chosen by pointer bit 4.
- R5: The access covers granules `floor(ptr/16)` through `floor((ptr+total-1)/16)`, where total is 1 to 256, so at most 17 granules. If every covered tag matches, the job passes.
- R6: Each needed tag byte is requested exactly once, in ascending address order, with one request outstanding at a time. No byte beyond the one that holds the first mismatching tag is requested.
- R7: On the first mismatch at granule index n, counted from 0, the job fails. The fault address is `ptr + roundup(x, 2^esz)`, where x is 0 for n = 0 and `16n - ptr[3:0]` otherwise.
- R8: The pointer tag is pointer bits [59:56]. Pointer bits [63:60] have no effect on the pass or fail result.
- R9: A start pulse that arrives while a job is in progress is ignored.
- R10: `done_o` is a one-cycle pulse. `pass_o` and `fault_addr_o` change only in the cycle `done_o` is high and then hold. `fault_addr_o` is 0 on a pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle job launch |
| ptr_i | input | 64 | Pointer, with the tag in [59:56] and the half select in [55] |
| total_i | input | 9 | Access size in bytes, 1 to 256 |
| esz_log2_i | input | 4 | Base-2 logarithm of the element size |
| tbi_en_i | input | 2 | Top-byte tagging enable, one bit per half |
| mall_en_i | input | 2 | Match-all rule enable, one bit per half |
| tag_req_o | output | 1 | Tag byte read request |
| tag_addr_o | output | 51 | Tag byte index (virtual address >> 5) |
| tag_rsp_valid_i | input | 1 | Tag byte response valid |
| tag_rsp_data_i | input | 8 | Tag byte, holding two packed granule tags |
| done_o | output | 1 | Job complete pulse |
| pass_o | output | 1 | Result: 1 means pass |
| fault_addr_o | output | 64 | Address reported for a failing job |

## Verification
The bench targets these corner cases:
- A walk that starts on the high nibble. Choosing the wrong nibble makes a clean access fail.
- A 256-byte unaligned access that touches 17 granules. An off-by-one in the granule count either misses the last byte or fetches one extra.
- A failure on the first granule. This must report the pointer itself rather than a granule base below it.
- Failures whose offsets need rounding up to 8-byte and 32-byte elements. A wrong roundup shows a shifted fault address.

The bench also checks the bypass cases with tag memory deliberately wrong. A wrong half select or match-all tag shows up as a failure, or as a request that the reference queue does not expect. A start pulse is injected mid-walk, and a design that accepted it would show a second `done_o` or a changed result.

// File: rtl/tagchk_pkg.sv
package tagchk_pkg;

    localparam int GRAN_LOG2  = 4;
    localparam int BYTE_SHIFT = GRAN_LOG2 + 1;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FETCH = 3'd1,
        S_WAIT  = 3'd2,
        S_CMP   = 3'd3,
        S_DONE  = 3'd4
    } tc_state_e;

endpackage

// File: rtl/tagchk_span.sv
module tagchk_span #(
    parameter int VA_W  = 56,
    parameter int TOT_W = 9,
    parameter int CNT_W = 5
) (
    input  logic [VA_W-1:0]  va_i,
    input  logic [3:0]       ptag_i,
    input  logic             half_i,
    input  logic [TOT_W-1:0] total_i,
    input  logic [1:0]       tbi_en_i,
    input  logic [1:0]       mall_en_i,
    output logic             bypass_o,
    output logic [CNT_W-1:0] gran_cnt_o
);
    import tagchk_pkg::*;

    logic [VA_W-1:0]           last_va;
    logic [VA_W-GRAN_LOG2-1:0] gdiff;
    logic                      tag_is_wild;

    // address of the final byte of the access
    assign last_va = va_i + VA_W'(total_i) - VA_W'(1);

    // granules spanned = last granule index - first granule index + 1
    assign gdiff      = last_va[VA_W-1:GRAN_LOG2] - va_i[VA_W-1:GRAN_LOG2];
    assign gran_cnt_o = CNT_W'(gdiff) + CNT_W'(1);

    // reserved tag of each half: all zeros below, all ones above
    assign tag_is_wild = (ptag_i == {4{half_i}});

    assign bypass_o = !tbi_en_i[half_i] || (mall_en_i[half_i] && tag_is_wild);

endmodule

// File: rtl/tagchk_fault.sv
module tagchk_fault #(
    parameter int PTR_W = 64,
    parameter int TOT_W = 9,
    parameter int CNT_W = 5,
    parameter int ESZ_W = 4
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [CNT_W-1:0] n_i,
    input  logic [ESZ_W-1:0] esz_log2_i,
    output logic [PTR_W-1:0] fault_addr_o
);
    import tagchk_pkg::*;

    localparam int OFS_W = TOT_W + 1;

    logic [OFS_W-1:0] gran_ofs;
    logic [OFS_W-1:0] elem_mask;
    logic [OFS_W-1:0] rounded;

    // distance from the pointer to the failing granule base, clamped at 0
    always_comb begin
        if (n_i == '0) begin
            gran_ofs = '0;
        end else begin
            gran_ofs = OFS_W'({n_i, {GRAN_LOG2{1'b0}}}) - OFS_W'(ptr_i[GRAN_LOG2-1:0]);
        end
    end

    assign elem_mask    = (OFS_W'(1) << esz_log2_i) - OFS_W'(1);
    assign rounded      = (gran_ofs + elem_mask) & ~elem_mask;
    assign fault_addr_o = ptr_i + PTR_W'(rounded);

endmodule

// File: rtl/tag_check_unit.sv
module tag_check_unit #(
    parameter int PTR_W    = 64,
    parameter int VA_W     = 56,
    parameter int MAX_LOG2 = 8,
    localparam int TOT_W   = MAX_LOG2 + 1,
    localparam int ESZ_W   = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W   = $clog2((2 ** MAX_LOG2) / 16 + 2),
    localparam int BA_W    = VA_W - 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [TOT_W-1:0] total_i,
    input  logic [ESZ_W-1:0] esz_log2_i,
    input  logic [1:0]       tbi_en_i,
    input  logic [1:0]       mall_en_i,
    output logic             tag_req_o,
    output logic [BA_W-1:0]  tag_addr_o,
    input  logic             tag_rsp_valid_i,
    input  logic [7:0]       tag_rsp_data_i,
    output logic             done_o,
    output logic             pass_o,
    output logic [PTR_W-1:0] fault_addr_o
);
    import tagchk_pkg::*;

    tc_state_e        state_q, state_d;

    logic [PTR_W-1:0] ptr_q;
    logic [ESZ_W-1:0] esz_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] n_q;
    logic             nib_q;
    logic [BA_W-1:0]  baddr_q;
    logic [7:0]       byte_q;
    logic [3:0]       ptag_q;
    logic             pass_q;
    logic [PTR_W-1:0] fault_q;

    logic             bypass;
    logic [CNT_W-1:0] gran_cnt;
    logic [PTR_W-1:0] fault_calc;
    logic [3:0]       cur_nib;
    logic             nib_match;
    logic             last_gran;
    logic             idle;

    tagchk_span #(
        .VA_W  (VA_W),
        .TOT_W (TOT_W),
        .CNT_W (CNT_W)
    ) u_span (
        .va_i       (ptr_i[VA_W-1:0]),
        .ptag_i     (ptr_i[VA_W+3:VA_W]),
        .half_i     (ptr_i[VA_W-1]),
        .total_i    (total_i),
        .tbi_en_i   (tbi_en_i),
        .mall_en_i  (mall_en_i),
        .bypass_o   (bypass),
        .gran_cnt_o (gran_cnt)
    );

    tagchk_fault #(
        .PTR_W (PTR_W),
        .TOT_W (TOT_W),
        .CNT_W (CNT_W),
        .ESZ_W (ESZ_W)
    ) u_fault (
        .ptr_i        (ptr_q),
        .n_i          (n_q),
        .esz_log2_i   (esz_q),
        .fault_addr_o (fault_calc)
    );

    assign cur_nib   = nib_q ? byte_q[7:4] : byte_q[3:0];
    assign nib_match = (cur_nib == ptag_q);
    assign last_gran = ((n_q + CNT_W'(1)) == cnt_q);
    assign idle      = (state_q == S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: bypass, launch, issue, response, mismatch,
    // final-granule, same-byte, next-byte, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = bypass ? S_DONE : S_FETCH;
                end
            end
            S_FETCH: state_d = S_WAIT;
            S_WAIT: begin
                if (tag_rsp_valid_i) begin
                    state_d = S_CMP;
                end
            end
            S_CMP: begin
                if (!nib_match || last_gran) begin
                    state_d = S_DONE;
                end else if (nib_q) begin
                    state_d = S_FETCH;
                end else begin
                    state_d = S_CMP;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // job registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            esz_q   <= '0;
            cnt_q   <= '0;
            n_q     <= '0;
            nib_q   <= 1'b0;
            baddr_q <= '0;
            byte_q  <= '0;
            ptag_q  <= '0;
            pass_q  <= 1'b0;
            fault_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        ptr_q   <= ptr_i;
                        esz_q   <= esz_log2_i;
                        cnt_q   <= gran_cnt;
                        n_q     <= '0;
                        nib_q   <= ptr_i[GRAN_LOG2];
                        baddr_q <= ptr_i[VA_W-1:BYTE_SHIFT];
                        ptag_q  <= ptr_i[VA_W+3:VA_W];
                        if (bypass) begin
                            pass_q  <= 1'b1;
                            fault_q <= '0;
                        end
                    end
                end
                S_WAIT: begin
                    if (tag_rsp_valid_i) begin
                        byte_q <= tag_rsp_data_i;
                    end
                end
                S_CMP: begin
                    if (!nib_match) begin
                        pass_q  <= 1'b0;
                        fault_q <= fault_calc;
                    end else if (last_gran) begin
                        pass_q  <= 1'b1;
                        fault_q <= '0;
                    end else begin
                        n_q <= n_q + CNT_W'(1);
                        if (nib_q) begin
                            nib_q   <= 1'b0;
                            baddr_q <= baddr_q + BA_W'(1);
                        end else begin
                            nib_q <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign tag_req_o    = (state_q == S_FETCH);
    assign tag_addr_o   = baddr_q;
    assign done_o       = (state_q == S_DONE);
    assign pass_o       = pass_q;
    assign fault_addr_o = fault_q;

endmodule

// File: rtl/tagchk_checker.sv
module tagchk_checker #(
    parameter int PTR_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             idle,
    input logic             half_i,
    input logic [3:0]       ptag_i,
    input logic [1:0]       tbi_en_i,
    input logic [1:0]       mall_en_i,
    input logic             tag_req_o,
    input logic             done_o,
    input logic             pass_o,
    input logic [PTR_W-1:0] fault_addr_o
);

    // R10: completion lasts exactly one cycle
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: never two requests back to back (one outstanding)
    a_r6_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req_o |=> !tag_req_o);

    // R6: requests only inside a running job
    a_r6_req_in_job: assert property (@(posedge clk) disable iff (!rst_n)
        tag_req_o |-> (!idle && !done_o));

    // R10: result changes only alongside completion
    a_r10_pass_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass_o) |-> done_o);

    a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr_o) |-> done_o);

    // R2: tagging off for the selected half passes in one cycle
    a_r2_tbi_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle && !tbi_en_i[half_i]) |=> (done_o && pass_o && !tag_req_o));

    // R3: match-all tag passes in one cycle
    a_r3_match_all: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && idle && tbi_en_i[half_i] && mall_en_i[half_i] && (ptag_i == {4{half_i}}))
        |=> (done_o && pass_o && !tag_req_o));

endmodule

bind tag_check_unit tagchk_checker #(.PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .idle         (idle),
    .half_i       (ptr_i[VA_W-1]),
    .ptag_i       (ptr_i[VA_W+3:VA_W]),
    .tbi_en_i     (tbi_en_i),
    .mall_en_i    (mall_en_i),
    .tag_req_o    (tag_req_o),
    .done_o       (done_o),
    .pass_o       (pass_o),
    .fault_addr_o (fault_addr_o)
);

// File: tb/tag_check_unit_bench.sv
module tag_check_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] ptr = '0;
    logic [8:0]  total = 9'd1;
    logic [3:0]  esz = '0;
    logic [1:0]  tbi = 2'b11;
    logic [1:0]  mall = 2'b00;
    logic        tag_req;
    logic [50:0] tag_addr;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_data = '0;
    logic        done;
    logic        pass;
    logic [63:0] fault;

    tag_check_unit u_tag_check_unit (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .ptr_i           (ptr),
        .total_i         (total),
        .esz_log2_i      (esz),
        .tbi_en_i        (tbi),
        .mall_en_i       (mall),
        .tag_req_o       (tag_req),
        .tag_addr_o      (tag_addr),
        .tag_rsp_valid_i (rsp_valid),
        .tag_rsp_data_i  (rsp_data),
        .done_o          (done),
        .pass_o          (pass),
        .fault_addr_o    (fault)
    );

    always #10 clk = ~clk;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc = 0;
    logic [7:0]  tmem [64];
    logic [50:0] exp_q [$];
    bit          job_on = 0;
    bit          done_seen = 0;
    int          done_cyc = 0;
    bit          exp_pass = 0;
    logic [63:0] exp_fault = '0;
    string       cur_req = "R0";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    always @(posedge clk) cyc++;

    // tag memory responder, latency 1..3 cycles after the request is seen
    int          rcnt = 0;
    int          nreq = 0;
    logic [50:0] raddr = '0;
    always @(negedge clk) begin
        if (rsp_valid) rsp_valid = 1'b0;
        if (rcnt > 0) begin
            rcnt--;
            if (rcnt == 0) begin
                rsp_valid = 1'b1;
                rsp_data  = tmem[raddr[5:0]];
            end
        end
        if (rst_n && tag_req) begin
            raddr = tag_addr;
            rcnt  = 1 + (nreq % 3);
            nreq++;
        end
    end

    // per-clock comparison against the reference expectations
    logic [50:0] front;
    always @(negedge clk) begin
        if (rst_n) begin
            if (tag_req) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R6", "unexpected tag request", 64'(tag_addr), 64'h0);
                end else begin
                    front = exp_q.pop_front();
                    chk(tag_addr == front, "R6/R4", "tag byte address", 64'(tag_addr), 64'(front));
                end
            end
            if (done) begin
                if (!job_on) begin
                    chk(0, "R9", "done with no job running", 64'h1, 64'h0);
                end else begin
                    job_on    = 0;
                    done_seen = 1;
                    done_cyc  = cyc;
                    chk(pass == exp_pass, cur_req, "pass", 64'(pass), 64'(exp_pass));
                    chk(fault == exp_fault, cur_req, "fault address", fault, exp_fault);
                    chk(exp_q.size() == 0, "R6", "bytes not fetched", 64'(exp_q.size()), 64'h0);
                end
            end
        end
    end

    // behavioural reference: returns 1 for a bypassed job
    function automatic bit model(input logic [63:0] p, input int tot, input int ez,
                                 input logic [1:0] tb, input logic [1:0] ma);
        logic       half;
        logic [3:0] pt;
        logic [3:0] nib;
        longint unsigned va, g0, g1, cnt, ga, b, prevb, x, m, off;
        half = p[55];
        pt   = p[59:56];
        exp_q.delete();
        exp_pass  = 1;
        exp_fault = '0;
        if (!tb[half] || (ma[half] && pt == {4{half}})) return 1;
        va    = longint'(p[55:0]);
        g0    = va >> 4;
        g1    = (va + longint'(tot) - 1) >> 4;
        cnt   = g1 - g0 + 1;
        prevb = 64'hFFFF_FFFF_FFFF_FFFF;
        for (longint unsigned i = 0; i < cnt; i++) begin
            ga = g0 + i;
            b  = ga >> 1;
            if (b != prevb) exp_q.push_back(b[50:0]);
            prevb = b;
            nib = ga[0] ? tmem[b % 64][7:4] : tmem[b % 64][3:0];
            if (nib != pt) begin
                exp_pass = 0;
                x   = (i == 0) ? 0 : i * 16 - (va & 15);
                m   = (64'd1 << ez) - 1;
                off = (x + m) & ~m;
                exp_fault = p + off;
                break;
            end
        end
        return 0;
    endfunction

    function automatic logic [63:0] mkptr(input logic [3:0] tg, input logic hf, input logic [54:0] va);
        return {4'h0, tg, hf, va};
    endfunction

    task automatic fill(input logic [3:0] tg);
        for (int i = 0; i < 64; i++) tmem[i] = {tg, tg};
    endtask

    task automatic run_job(input logic [63:0] p, input int tot, input int ez,
                           input logic [1:0] tb, input logic [1:0] ma,
                           input string req, input bit poke);
        bit          byp;
        int          t0;
        int          k;
        logic [63:0] hold_f;
        logic        hold_p;
        @(negedge clk);
        byp       = model(p, tot, ez, tb, ma);
        cur_req   = req;
        done_seen = 0;
        job_on    = 1;
        ptr   = p;
        total = 9'(tot);
        esz   = 4'(ez);
        tbi   = tb;
        mall  = ma;
        start = 1'b1;
        t0    = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            ptr   = p ^ (64'hF << 56);
            tbi   = 2'b00;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (!done_seen && k < 400) begin
            @(negedge clk);
            k++;
        end
        if (!done_seen) begin
            chk(0, req, "job timed out", 64'h0, 64'h1);
            job_on = 0;
        end else if (byp) begin
            chk(done_cyc - t0 == 1, req, "bypass latency", 64'(done_cyc - t0), 64'h1);
        end
        hold_p = pass;
        hold_f = fault;
        repeat (3) @(negedge clk);
        chk(!done && pass == hold_p && fault == hold_f, "R10", "result held after done",
            {pass, fault[62:0]}, {hold_p, hold_f[62:0]});
    endtask

    initial begin
        #3000000;
        chk(0, "WDOG", "watchdog expired", 64'h0, 64'h1);
        summary();
        $finish;
    end

    initial begin
        fill(4'h5);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!done && !tag_req && !pass && fault == 0, "R1", "reset outputs",
            {done, tag_req, pass, fault[60:0]}, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 R8: single granule, matching
        fill(4'h5);
        run_job(mkptr(4'h5, 1'b0, 55'h100), 16, 4, 2'b11, 2'b00, "R5", 0);
        // R4 R5: 17 granules, starting on the high nibble, half 1
        fill(4'h9);
        run_job(mkptr(4'h9, 1'b1, 55'h218), 256, 0, 2'b11, 2'b11, "R4", 0);
        // R7: mismatch at granule 2, 8-byte elements
        fill(4'h3);
        tmem[9][3:0] = 4'hA;
        run_job(mkptr(4'h3, 1'b0, 55'h104), 64, 3, 2'b11, 2'b00, "R7", 0);
        // R7: mismatch at the first granule (high nibble start)
        fill(4'h3);
        tmem[1][7:4] = 4'h0;
        run_job(mkptr(4'h3, 1'b0, 55'h038), 40, 0, 2'b11, 2'b00, "R7", 0);
        // R7: mismatch at granule 3, 32-byte elements, round up
        fill(4'h6);
        tmem[2][7:4] = 4'h1;
        run_job(mkptr(4'h6, 1'b0, 55'h020), 128, 5, 2'b11, 2'b00, "R7", 0);
        // R2: tagging off for the selected half, memory wrong
        fill(4'h1);
        run_job(mkptr(4'h7, 1'b0, 55'h300), 64, 0, 2'b10, 2'b00, "R2", 0);
        run_job(mkptr(4'h7, 1'b1, 55'h300), 64, 0, 2'b01, 2'b00, "R2", 0);
        // R2: other half disabled only, so this one is checked and fails
        run_job(mkptr(4'h7, 1'b1, 55'h300), 64, 0, 2'b10, 2'b00, "R2", 0);
        // R3: match-all tags
        run_job(mkptr(4'h0, 1'b0, 55'h040), 32, 0, 2'b11, 2'b01, "R3", 0);
        run_job(mkptr(4'hF, 1'b1, 55'h040), 32, 0, 2'b11, 2'b10, "R3", 0);
        // R3: match-all enabled on the other half only: checked, fails
        run_job(mkptr(4'hF, 1'b1, 55'h040), 32, 0, 2'b11, 2'b01, "R3", 0);
        // R8: upper pointer bits do not take part
        fill(4'hC);
        run_job(mkptr(4'hC, 1'b0, 55'h480) | (64'hA << 60), 48, 1, 2'b11, 2'b00, "R8", 0);
        // R9: a start pulse during a long walk is ignored
        fill(4'h2);
        run_job(mkptr(4'h2, 1'b0, 55'h008), 256, 2, 2'b11, 2'b00, "R9", 1);
        fill(4'h2);
        tmem[6][7:4] = 4'h4;
        run_job(mkptr(4'h2, 1'b1, 55'h018), 200, 4, 2'b11, 2'b00, "R9", 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule